// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

The block lays a small two-colour image over a video pixel stream. The raster logic gives it the screen coordinate of the current pixel and the background colour there. One clock later the block returns either that background colour or one of two programmable cursor colours. The cursor image is at most 64 by 64 pixels. It is held in a local 1024-byte RAM that the host loads byte by byte. Each image line has two planes, a source plane and a mask plane.

A small register set configures the block. It holds the cursor position, the two 24-bit colours and a control byte. The stored position carries a bias of 64, so the cursor can hang partly off the left or top edge of the screen. A new position never takes effect in the middle of a frame. It waits in a shadow register and is copied to the active position at the start of vertical blanking. A two-state machine tracks this hand-over. In state `ST_SYNCED` the active and shadow positions agree. In state `ST_PENDING` a new position is waiting. The transition *position write* always leads to `ST_PENDING`. The transition *blanking start* copies the shadow value into the active position and returns to `ST_SYNCED`, unless a new position write arrives in the same cycle.

Top module: `hwcur_overlay`

## Requirements
- R1: After reset `out_pixel` is 0, the control byte is 0x00 (cursor off), both positions are 0 and both colours are 0.
- R2: `out_pixel` is registered. The value seen after a clock edge is computed from `pix_x`, `pix_y` and `bg_pixel` as sampled at that edge. It does not change between edges.
- R3: Only a control byte of 0x03 turns the cursor on, in two-colour mask/source mode. With 0x00 or any other value, `out_pixel` is the previous cycle's `bg_pixel`.
- R4: Image byte address `16*row + k`, for k from 0 to 7, holds source-plane pixels `8k` to `8k+7` of that row. Address `16*row + 8 + k` holds the mask-plane pixels for the same columns. Bit 7 of each byte is the leftmost of its eight pixels.
- R5: Inside the cursor, a mask bit of 0 shows the background. A mask bit of 1 shows colour 1 when the source bit is 1, and colour 0 when the source bit is 0.
- R6: `host_sel` 1 writes colour 0 and `host_sel` 2 writes colour 1. In each colour word, red is in bits 23:16, green in 15:8 and blue in 7:0. `host_sel` 3 writes the control byte from bits 7:0. Colours and control apply from the next pixel on.
- R7: `host_sel` 0 writes the position word, with x in bits 11:0 and y in bits 27:16. Bits 15:12 and 31:28 are ignored.
- R8: Cursor pixel (c, r) appears at screen (stored_x − 64 + c, stored_y − 64 + r). Stored values below 64 clip the cursor off the left or top edge.
- R9: A position write does not move the cursor right away. The new position becomes active at the next rising edge of `vblank`, meaning the first cycle in which `vblank` is sampled high after being sampled low.
- R10: A position write in the same cycle as a `vblank` rise is held for the following rise. The rise applies the value that was already waiting. A write made while `vblank` stays high also waits for the next rise.
- R11: Pixels outside the 64×64 cursor window always show the background.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 2 | Register select: 0 position, 1 colour 0, 2 colour 1, 3 control |
| host_wdata | input | 32 | Register write data |
| img_we | input | 1 | Image RAM write strobe |
| img_addr | input | 10 | Image RAM byte address |
| img_wdata | input | 8 | Image RAM byte |
| vblank | input | 1 | Vertical blanking flag from the raster logic |
| pix_x | input | 12 | Screen column of the current pixel |
| pix_y | input | 12 | Screen row of the current pixel |
| bg_pixel | input | 24 | Background colour of the current pixel |
| out_pixel | output | 24 | Composited pixel, one cycle late |

## Verification
The bench sweeps the cursor window one pixel past every edge, with an irregular image. A mistake in plane order or bit order therefore shows up as wrong colours at particular columns, and a window boundary that is off by one shows up as cursor colour on a background pixel.

It also places the cursor with biased values below 64. A design that ignored the bias, or compared coordinates without a sign, would draw the cursor at the wrong place or not at all.

The hand-over checks are the most exacting. One writes a position in the very cycle that `vblank` rises. Another writes while `vblank` is held high. A design that applied the incoming word directly, or that copied the position on a level instead of an edge, would move the cursor a frame early. Finally, writes with junk in the ignored bit ranges and control values other than 0x03 catch decoders that are too loose.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

    // register select codes on the host port
    typedef enum logic [1:0] {
        SEL_POS  = 2'd0,
        SEL_COL0 = 2'd1,
        SEL_COL1 = 2'd2,
        SEL_CTRL = 2'd3
    } hsel_e;

    // position hand-over states
    typedef enum logic {
        ST_SYNCED  = 1'b0,
        ST_PENDING = 1'b1
    } pos_state_e;

    // control byte value that enables the two-colour mode
    localparam logic [7:0] CTRL_TWO_COLOUR = 8'h03;

    // image planes inside one cursor line
    localparam int PLANE_SRC = 0;
    localparam int PLANE_MSK = 1;

endpackage

// File: rtl/hwcur_regs.sv
module hwcur_regs
    import hwcur_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int PIX_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [1:0]         host_sel,
    input  logic [31:0]        host_wdata,
    input  logic               vblank,
    output logic [COORD_W-1:0] act_x,
    output logic [COORD_W-1:0] act_y,
    output logic [PIX_W-1:0]   colour0,
    output logic [PIX_W-1:0]   colour1,
    output logic [7:0]         ctrl
);

    localparam int Y_LSB = 16;

    pos_state_e         state, state_n;
    logic               vblank_q;
    logic               vb_rise;
    logic               pos_wr;
    logic [COORD_W-1:0] pend_x, pend_y;
    logic               unused_wdata;

    assign unused_wdata = ^host_wdata;
    assign vb_rise = vblank & ~vblank_q;
    assign pos_wr  = host_we && (hsel_e'(host_sel) == SEL_POS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SYNCED;
        end else begin
            state <= state_n;
        end
    end

    // transitions: position write, blanking start
    always_comb begin
        state_n = state;
        unique case (state)
            ST_SYNCED: begin
                if (pos_wr) state_n = ST_PENDING;
            end
            ST_PENDING: begin
                if (pos_wr)       state_n = ST_PENDING;
                else if (vb_rise) state_n = ST_SYNCED;
            end
            default: state_n = ST_SYNCED;
        endcase
    end

    // outputs and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vblank_q <= 1'b0;
            pend_x   <= '0;
            pend_y   <= '0;
            act_x    <= '0;
            act_y    <= '0;
            colour0  <= '0;
            colour1  <= '0;
            ctrl     <= 8'h00;
        end else begin
            vblank_q <= vblank;
            if (state == ST_PENDING && vb_rise) begin
                act_x <= pend_x;
                act_y <= pend_y;
            end
            if (host_we) begin
                unique case (hsel_e'(host_sel))
                    SEL_POS: begin
                        pend_x <= host_wdata[COORD_W-1:0];
                        pend_y <= host_wdata[Y_LSB +: COORD_W];
                    end
                    SEL_COL0: colour0 <= host_wdata[PIX_W-1:0];
                    SEL_COL1: colour1 <= host_wdata[PIX_W-1:0];
                    SEL_CTRL: ctrl    <= host_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    // R9: the active position moves only on a blanking rise
    assert_pos_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vb_rise |=> ($stable(act_x) && $stable(act_y)));

    // R9: a position write always leaves a value waiting
    assert_write_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pos_wr |=> (state == ST_PENDING));

    // R10: in the synced state nothing is waiting
    assert_sync_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNCED) |-> (act_x == pend_x && act_y == pend_y));

endmodule

// File: rtl/hwcur_bitmap.sv
module hwcur_bitmap
    import hwcur_pkg::*;
#(
    parameter int CUR_DIM = 64,
    parameter int IMG_AW  = $clog2(CUR_DIM * CUR_DIM / 4)
) (
    input  logic                       clk,
    input  logic                       img_we,
    input  logic [IMG_AW-1:0]          img_addr,
    input  logic [7:0]                 img_wdata,
    input  logic [$clog2(CUR_DIM)-1:0] rd_row,
    input  logic [$clog2(CUR_DIM)-1:0] rd_col,
    output logic                       src_bit,
    output logic                       msk_bit
);

    localparam int RW          = $clog2(CUR_DIM);
    localparam int BW          = $clog2(CUR_DIM / 8);
    localparam int PLANE_BYTES = CUR_DIM * CUR_DIM / 8;
    localparam int IW          = RW + BW;

    logic          wr_plane;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;
    logic [2:0]    bit_sel;
    logic [1:0][7:0] rd_byte;

    // address layout: row, then plane, then byte within the plane
    assign wr_plane = img_addr[BW];
    assign wr_idx   = {img_addr[IMG_AW-1 -: RW], img_addr[BW-1:0]};
    assign rd_idx   = {rd_row, rd_col[RW-1:3]};
    assign bit_sel  = ~rd_col[2:0];

    for (genvar p = 0; p < 2; p++) begin : g_plane
        logic [7:0] mem [PLANE_BYTES];

        always_ff @(posedge clk) begin
            if (img_we && (wr_plane == 1'(p))) begin
                mem[wr_idx] <= img_wdata;
            end
        end

        assign rd_byte[p] = mem[rd_idx];
    end

    assign src_bit = rd_byte[PLANE_SRC][bit_sel];
    assign msk_bit = rd_byte[PLANE_MSK][bit_sel];

endmodule

// File: rtl/hwcur_pixel.sv
module hwcur_pixel
    import hwcur_pkg::*;
#(
    parameter int CUR_DIM = 64,
    parameter int COORD_W = 12,
    parameter int PIX_W   = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [COORD_W-1:0]         pix_x,
    input  logic [COORD_W-1:0]         pix_y,
    input  logic [PIX_W-1:0]           bg_pixel,
    input  logic [COORD_W-1:0]         act_x,
    input  logic [COORD_W-1:0]         act_y,
    input  logic [PIX_W-1:0]           colour0,
    input  logic [PIX_W-1:0]           colour1,
    input  logic [7:0]                 ctrl,
    input  logic                       src_bit,
    input  logic                       msk_bit,
    output logic [$clog2(CUR_DIM)-1:0] rd_row,
    output logic [$clog2(CUR_DIM)-1:0] rd_col,
    output logic [PIX_W-1:0]           out_pixel
);

    localparam int RW = $clog2(CUR_DIM);
    localparam int DW = COORD_W + 2;

    logic [DW-1:0]    dx, dy;
    logic             hit;
    logic [PIX_W-1:0] pix_n;

    // offset into the cursor, bias removed; negative wraps high
    assign dx  = DW'(pix_x) + DW'(CUR_DIM) - DW'(act_x);
    assign dy  = DW'(pix_y) + DW'(CUR_DIM) - DW'(act_y);
    assign hit = (dx[DW-1:RW] == '0) && (dy[DW-1:RW] == '0);

    assign rd_col = dx[RW-1:0];
    assign rd_row = dy[RW-1:0];

    always_comb begin
        pix_n = bg_pixel;
        if (ctrl == CTRL_TWO_COLOUR && hit && msk_bit) begin
            pix_n = src_bit ? colour1 : colour0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_pixel <= '0;
        else        out_pixel <= pix_n;
    end

    // R3: a disabled cursor passes the delayed background
    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl != CTRL_TWO_COLOUR) |=> (out_pixel == $past(bg_pixel)));

    // R5: a clear mask bit shows the background
    assert_mask_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !msk_bit) |=> (out_pixel == $past(bg_pixel)));

    // R11: outside the window the background passes
    assert_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (out_pixel == $past(bg_pixel)));

    // R2: the output is always one of the three candidates of the previous cycle
    assert_out_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_pixel == $past(bg_pixel) || out_pixel == $past(colour0)
                  || out_pixel == $past(colour1)));

endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
    import hwcur_pkg::*;
#(
    parameter int CUR_DIM = 64,
    parameter int COORD_W = 12,
    parameter int PIX_W   = 24,
    parameter int IMG_AW  = $clog2(CUR_DIM * CUR_DIM / 4)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [1:0]         host_sel,
    input  logic [31:0]        host_wdata,
    input  logic               img_we,
    input  logic [IMG_AW-1:0]  img_addr,
    input  logic [7:0]         img_wdata,
    input  logic               vblank,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [PIX_W-1:0]   bg_pixel,
    output logic [PIX_W-1:0]   out_pixel
);

    localparam int RW = $clog2(CUR_DIM);

    logic [COORD_W-1:0] act_x, act_y;
    logic [PIX_W-1:0]   colour0, colour1;
    logic [7:0]         ctrl;
    logic [RW-1:0]      rd_row, rd_col;
    logic               src_bit, msk_bit;

    hwcur_regs #(
        .COORD_W (COORD_W),
        .PIX_W   (PIX_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .vblank     (vblank),
        .act_x      (act_x),
        .act_y      (act_y),
        .colour0    (colour0),
        .colour1    (colour1),
        .ctrl       (ctrl)
    );

    hwcur_bitmap #(
        .CUR_DIM (CUR_DIM),
        .IMG_AW  (IMG_AW)
    ) bitmap_i (
        .clk       (clk),
        .img_we    (img_we),
        .img_addr  (img_addr),
        .img_wdata (img_wdata),
        .rd_row    (rd_row),
        .rd_col    (rd_col),
        .src_bit   (src_bit),
        .msk_bit   (msk_bit)
    );

    hwcur_pixel #(
        .CUR_DIM (CUR_DIM),
        .COORD_W (COORD_W),
        .PIX_W   (PIX_W)
    ) pixel_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .bg_pixel  (bg_pixel),
        .act_x     (act_x),
        .act_y     (act_y),
        .colour0   (colour0),
        .colour1   (colour1),
        .ctrl      (ctrl),
        .src_bit   (src_bit),
        .msk_bit   (msk_bit),
        .rd_row    (rd_row),
        .rd_col    (rd_col),
        .out_pixel (out_pixel)
    );

endmodule

// File: tb/hwcur_overlay_tb_top.sv
module hwcur_overlay_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [31:0] host_wdata = '0;
    logic        img_we = 1'b0;
    logic [9:0]  img_addr = '0;
    logic [7:0]  img_wdata = '0;
    logic        vblank = 1'b0;
    logic [11:0] pix_x = '0;
    logic [11:0] pix_y = '0;
    logic [23:0] bg_pixel = '0;
    logic [23:0] out_pixel;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state, set by the tests from the requirements
    logic [7:0]  bm [1024];
    logic [7:0]  m_ctrl = 8'h00;
    logic [23:0] m_c0 = '0;
    logic [23:0] m_c1 = '0;
    int          m_ax = 0;
    int          m_ay = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwcur_overlay dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .img_we     (img_we),
        .img_addr   (img_addr),
        .img_wdata  (img_wdata),
        .vblank     (vblank),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .bg_pixel   (bg_pixel),
        .out_pixel  (out_pixel)
    );

    task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %06h expected %06h", req, act, exp);
        end
    endtask

    // R4, R5, R8, R11 model
    function automatic logic [23:0] model(input int x, input int y, input logic [23:0] bg);
        int dx, dy;
        logic s, m;
        dx = x + 64 - m_ax;
        dy = y + 64 - m_ay;
        if (m_ctrl != 8'h03) return bg;
        if (dx < 0 || dx > 63 || dy < 0 || dy > 63) return bg;
        s = bm[dy*16 + dx/8][7 - dx%8];
        m = bm[dy*16 + 8 + dx/8][7 - dx%8];
        if (!m) return bg;
        return s ? m_c1 : m_c0;
    endfunction

    task automatic pix(input int x, input int y, input logic [23:0] bg, input string req);
        @(negedge clk);
        pix_x = 12'(x);
        pix_y = 12'(y);
        bg_pixel = bg;
        @(posedge clk);
        #1;
        check(out_pixel, model(x, y, bg), req);
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_sel = sel;
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic vb_pulse();
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
    endtask

    function automatic logic [23:0] bgval(input int x, input int y);
        return 24'((x * 131 + y * 977) ^ 24'h5A5A5A);
    endfunction

    task automatic t_reset();
        pix(5, 5, 24'h123456, "R1");
        check(out_pixel, 24'h123456, "R1");
    endtask

    task automatic t_load_image();
        for (int a = 0; a < 1024; a++) begin
            int row, k;
            row = a / 16;
            k = a % 16;
            bm[a] = (k < 8) ? 8'((row * 37 + k * 91 + 3) & 255)
                            : 8'(((row * 5 + k * 17) ^ 8'h3C) & 255);
            @(negedge clk);
            img_we = 1'b1;
            img_addr = 10'(a);
            img_wdata = bm[a];
        end
        @(negedge clk);
        img_we = 1'b0;
    endtask

    task automatic t_sweep();
        // R6 colour words; R7 position word; R9 applied on rise
        m_c0 = 24'h11_22_33;
        m_c1 = 24'hAA_BB_CC;
        host_wr(2'd1, {8'h00, m_c0});
        host_wr(2'd2, {8'h00, m_c1});
        host_wr(2'd3, 32'h0000_0003);
        m_ctrl = 8'h03;
        host_wr(2'd0, {4'h0, 12'(64 + 50), 4'h0, 12'(64 + 100)});
        vb_pulse();
        m_ax = 164;
        m_ay = 114;
        for (int y = 49; y <= 114; y++) begin
            for (int x = 99; x <= 164; x++) begin
                pix(x, y, bgval(x, y), "R4 R5 R8 R11");
            end
        end
    endtask

    task automatic t_latency();
        // R2: value held between edges, then follows the sampled input
        pix(0, 0, 24'h0F0F0F, "R2");
        @(negedge clk);
        bg_pixel = 24'hF0F0F0;
        #1;
        check(out_pixel, 24'h0F0F0F, "R2");
        @(posedge clk);
        #1;
        check(out_pixel, 24'hF0F0F0, "R2");
    endtask

    task automatic t_pending();
        // R9: write without a blanking rise leaves old position active
        host_wr(2'd0, {4'h0, 12'(64 + 300), 4'h0, 12'(64 + 400)});
        for (int i = 0; i < 8; i++) pix(100 + i, 50 + i, 24'h000001, "R9");
        pix(400, 300, 24'h000002, "R9");
        vb_pulse();
        m_ax = 464;
        m_ay = 364;
        for (int i = 0; i < 8; i++) pix(400 + i * 5, 300 + i * 7, 24'h000003, "R9");
    endtask

    task automatic t_same_cycle();
        // R10: a write in the cycle of the rise waits for the next rise
        host_wr(2'd0, {4'h0, 12'(64 + 10), 4'h0, 12'(64 + 20)});
        @(negedge clk);
        vblank = 1'b1;
        host_we = 1'b1;
        host_sel = 2'd0;
        host_wdata = {4'h0, 12'(64 + 600), 4'h0, 12'(64 + 700)};
        @(negedge clk);
        host_we = 1'b0;
        vblank = 1'b0;
        m_ax = 84;
        m_ay = 74;
        for (int i = 0; i < 8; i++) pix(20 + i * 3, 10 + i * 4, 24'h000004, "R10");
        // R10: a write while vblank stays high also waits
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        host_we = 1'b1;
        host_wdata = {4'h0, 12'(64 + 200), 4'h0, 12'(64 + 250)};
        @(negedge clk);
        host_we = 1'b0;
        vblank = 1'b0;
        m_ax = 764;
        m_ay = 664;
        for (int i = 0; i < 8; i++) pix(700 + i * 2, 600 + i * 5, 24'h000005, "R10");
        vb_pulse();
        m_ax = 314;
        m_ay = 264;
        for (int i = 0; i < 8; i++) pix(250 + i * 6, 200 + i * 3, 24'h000006, "R10");
    endtask

    task automatic t_clip_and_ignored_bits();
        // R7: junk in bits 31:28 and 15:12 ignored; R8: biased below 64 clips
        host_wr(2'd0, {4'hF, 12'd20, 4'hA, 12'd10});
        vb_pulse();
        m_ax = 10;
        m_ay = 20;
        for (int y = 0; y < 22; y++) begin
            for (int x = 0; x < 12; x++) pix(x, y, bgval(x, y), "R7 R8");
        end
    endtask

    task automatic t_ctrl_modes();
        host_wr(2'd0, {4'h0, 12'd64, 4'h0, 12'd64});
        vb_pulse();
        m_ax = 64;
        m_ay = 64;
        // R6: colour change applies to the next pixel
        m_c1 = 24'h01_80_FE;
        host_wr(2'd2, {8'hFF, m_c1});
        for (int x = 0; x < 16; x++) pix(x, 3, bgval(x, 3), "R6");
        // R3: other control values disable the overlay
        host_wr(2'd3, 32'h0000_0001);
        m_ctrl = 8'h01;
        for (int x = 0; x < 16; x++) pix(x, 3, bgval(x, 3), "R3");
        host_wr(2'd3, 32'h0000_0083);
        m_ctrl = 8'h83;
        for (int x = 0; x < 16; x++) pix(x, 3, bgval(x, 3), "R3");
        host_wr(2'd3, 32'h0000_0000);
        m_ctrl = 8'h00;
        for (int x = 0; x < 16; x++) pix(x, 3, bgval(x, 3), "R3");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_image();
        t_sweep();
        t_latency();
        t_pending();
        t_same_cycle();
        t_clip_and_ignored_bits();
        t_ctrl_modes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: output register cleared while reset is held
        #(CLK_PERIOD * 2 + 1);
        check(out_pixel, 24'h000000, "R1");
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule